// File: doc/BRIEF.md
# Vectored Interrupt Controller with Masks

This block arbitrates 32 interrupt and exception request lines for a small 32-bit core. From the pending requests it picks a single winner and issues a one-cycle take strobe. Along with the strobe it gives the winning vector number and the word address of that vector's entry in a handler table, which sits at a fixed base address. The core then fetches the handler pointer from that address. Saving register context and returning from the handler are not part of this block.

Vector 0 and vectors 2 to 5 are synchronous exceptions. Vector 1 is the non-maskable hardware-error line. Vector 6 is the software interrupt, and vectors 7 to 31 are platform lines. The controller holds a global interrupt enable, which the core controls with set and clear commands and which it sees as bit 4 of its flags word. It also holds a 32-bit per-vector enable mask, which software can overwrite. On every acceptance the hardware clears the global enable and the mask bit of the taken vector. Only a software mask write turns that mask bit back on.

Top module: `irq_vector_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `take` is 0, `irq_en` is 0, every bit of `mask` is 1, `take_vec` is 0 and `entry_addr` equals the table base (default 32'h0000_0100).
- R2: If any request is eligible at a clock edge, `take` is 1 for the following cycle and `take_vec` holds the lowest-numbered eligible vector. `take_vec` and `entry_addr` keep their values on cycles without a take.
- R3: On a take, `entry_addr` equals the table base plus `take_vec`, because the table is word addressed.
- R4: A vector from 6 to 31 is eligible only when its request is high, its `mask` bit is 1 and `irq_en` is 1.
- R5: Vectors 0, 2, 3, 4 and 5 are eligible when the request is high and the `mask` bit is 1, whatever the value of `irq_en`.
- R6: Vector 1 ignores both `irq_en` and its `mask` bit. It is eligible only in the first cycle its request is high after a cycle in which it was low, so a request held high is taken once.
- R7: Every take leaves `irq_en` at 0.
- R8: Every take clears the `mask` bit of the taken vector. No mask bit goes from 0 to 1 except through a mask write.
- R9: `en_set` sets `irq_en` at the next edge and `en_clr` clears it. If both are high, the clear wins. If a take happens in the same cycle, the take's clear wins over `en_set`.
- R10: `mask_we` loads `mask_wdata` into `mask` at the next edge. If a take happens in the same cycle, the written value is stored with the taken vector's bit forced to 0. Eligibility is always judged on the mask and enable held before the edge.
- R11: A request held high does not produce a second take until software re-enables the relevant state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 32 | Request lines, bit n is vector n |
| en_set | input | 1 | Set the global interrupt enable |
| en_clr | input | 1 | Clear the global interrupt enable |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 32 | New mask value, 1 enables a vector |
| take | output | 1 | One-cycle acceptance strobe |
| take_vec | output | 5 | Vector number of the last acceptance |
| entry_addr | output | 32 | Table entry word address of the last acceptance |
| irq_en | output | 1 | Global interrupt enable (flags bit 4) |
| mask | output | 32 | Current per-vector enable mask |

## Verification
An acceptance can land in the same cycle as a software update of the state it changes: a take can coincide with `en_set`, or with a mask write. To provoke this, the bench raises an exception request in the same cycle that it pulses `en_set` or writes the mask. It then checks that `irq_en` stays 0 and that the stored mask is the written word with the winner's bit cleared. A behavioural reference model checks every cycle, through directed phases and a long run of random requests and commands.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int unsigned VIC_NUM_SRC  = 32;
    localparam int unsigned VIC_ADDR_W   = 32;
    localparam int unsigned VIC_NMI_VEC  = 1;
    // Synchronous exception vectors 0,2,3,4,5: mask-gated, enable-independent
    localparam logic [VIC_NUM_SRC-1:0] VIC_SYNC_SET = 32'h0000_003D;
    localparam logic [VIC_ADDR_W-1:0]  VIC_TABLE_BASE = 32'h0000_0100;
endpackage

// File: rtl/vic_elig.sv
module vic_elig #(
    parameter int unsigned N    = 32,
    parameter int unsigned NMI  = 1,
    parameter logic [N-1:0] SYNC = '0
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] mask_q,
    input  logic         gie_q,
    input  logic         nmi_prev_q,
    output logic [N-1:0] elig
);
    for (genvar g = 0; g < N; g++) begin : g_src
        if (g == NMI) begin : g_nmi
            assign elig[g] = req[g] & ~nmi_prev_q;
        end else if (SYNC[g]) begin : g_sync
            assign elig[g] = req[g] & mask_q[g];
        end else begin : g_plat
            assign elig[g] = req[g] & mask_q[g] & gie_q;
        end
    end
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int unsigned N  = 32,
    parameter int unsigned VW = $clog2(N)
) (
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  grant,
    output logic          found,
    output logic [VW-1:0] idx
);
    logic [N:0] below;

    assign below[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_chain
        assign below[g+1] = below[g] | elig[g];
        assign grant[g]   = elig[g] & ~below[g];
    end
    assign found = below[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) begin
                idx = idx | VW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import vic_pkg::*;
#(
    parameter int unsigned        N    = VIC_NUM_SRC,
    parameter int unsigned        AW   = VIC_ADDR_W,
    parameter int unsigned        NMI  = VIC_NMI_VEC,
    parameter logic [N-1:0]       SYNC = VIC_SYNC_SET,
    parameter logic [AW-1:0]      BASE = VIC_TABLE_BASE
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [N-1:0]           req,
    input  logic                   en_set,
    input  logic                   en_clr,
    input  logic                   mask_we,
    input  logic [N-1:0]           mask_wdata,
    output logic                   take,
    output logic [$clog2(N)-1:0]   take_vec,
    output logic [AW-1:0]          entry_addr,
    output logic                   irq_en,
    output logic [N-1:0]           mask
);
    localparam int unsigned VW = $clog2(N);

    typedef struct packed {
        logic          take;
        logic [VW-1:0] vec;
        logic [AW-1:0] addr;
        logic          gie;
        logic [N-1:0]  mask;
        logic          nmi_prev;
    } vic_state_t;

    localparam vic_state_t RST_STATE = '{
        take: 1'b0, vec: '0, addr: BASE, gie: 1'b0, mask: '1, nmi_prev: 1'b0
    };

    vic_state_t    st_d, st_q;
    logic [N-1:0]  elig, grant;
    logic          found;
    logic [VW-1:0] win;

    vic_elig #(.N(N), .NMI(NMI), .SYNC(SYNC)) i_elig (
        .req        (req),
        .mask_q     (st_q.mask),
        .gie_q      (st_q.gie),
        .nmi_prev_q (st_q.nmi_prev),
        .elig       (elig)
    );

    vic_prio #(.N(N), .VW(VW)) i_prio (
        .elig  (elig),
        .grant (grant),
        .found (found),
        .idx   (win)
    );

    always_comb begin
        st_d          = st_q;
        st_d.take     = found;
        st_d.nmi_prev = req[NMI];
        if (en_clr) begin
            st_d.gie = 1'b0;
        end else if (en_set) begin
            st_d.gie = 1'b1;
        end
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        if (found) begin
            st_d.vec       = win;
            st_d.addr      = BASE + AW'(win);
            st_d.gie       = 1'b0;
            st_d.mask[win] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign take       = st_q.take;
    assign take_vec   = st_q.vec;
    assign entry_addr = st_q.addr;
    assign irq_en     = st_q.gie;
    assign mask       = st_q.mask;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2
    AST_ADDR_MATCHES: assert property (@(posedge clk) disable iff (rst)
        st_q.take |-> (st_q.addr == BASE + AW'(st_q.vec))); // R3
    AST_PLAT_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        (st_q.take && !SYNC[st_q.vec] && st_q.vec != VW'(NMI)) |-> $past(st_q.gie)); // R4
    AST_NMI_EDGE_ONLY: assert property (@(posedge clk) disable iff (rst)
        (st_q.take && st_q.vec == VW'(NMI)) |-> ($past(req[NMI]) && !$past(st_q.nmi_prev))); // R6
    AST_TAKE_DROPS_GIE: assert property (@(posedge clk) disable iff (rst)
        st_q.take |-> !st_q.gie); // R7
    AST_TAKE_DROPS_MASK: assert property (@(posedge clk) disable iff (rst)
        st_q.take |-> !st_q.mask[st_q.vec]); // R8
    AST_MASK_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
        !$past(mask_we) |-> ((st_q.mask & ~$past(st_q.mask)) == '0)); // R8
endmodule

// File: tb/test_irq_vector_ctrl.sv
`timescale 1ns/1ps
module test_irq_vector_ctrl;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] req = '0;
    logic        en_set = 1'b0, en_clr = 1'b0, mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic        take, irq_en;
    logic [4:0]  take_vec;
    logic [31:0] entry_addr, mask;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit          m_take, m_gie, m_nprev;
    int          m_vec;
    logic [31:0] m_addr, m_mask;

    always #4 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst(rst), .req(req), .en_set(en_set), .en_clr(en_clr),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .take(take),
        .take_vec(take_vec), .entry_addr(entry_addr), .irq_en(irq_en),
        .mask(mask)
    );

    function automatic bit is_sync(int v);
        return (v == 0) || (v >= 2 && v <= 5);
    endfunction

    task automatic model_edge();
        int win = -1;
        bit gie_n;
        logic [31:0] mask_n;
        if (rst) begin
            m_take = 0; m_gie = 0; m_nprev = 0; m_vec = 0;
            m_addr = BASE; m_mask = '1;
            return;
        end
        for (int v = 0; v < 32; v++) begin
            if (win < 0 && req[v]) begin
                if (v == 1) begin
                    if (!m_nprev) win = v;
                end else if (m_mask[v] && (is_sync(v) || m_gie)) begin
                    win = v;
                end
            end
        end
        gie_n = m_gie;
        if (en_clr) gie_n = 0;
        else if (en_set) gie_n = 1;
        mask_n = mask_we ? mask_wdata : m_mask;
        if (win >= 0) begin
            gie_n = 0;
            mask_n[win] = 1'b0;
            m_vec  = win;
            m_addr = BASE + 32'(win);
        end
        m_take  = (win >= 0);
        m_gie   = gie_n;
        m_mask  = mask_n;
        m_nprev = req[1];
    endtask

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "take (R2)", 32'(take), 32'(m_take));
        chk(tag, "vector (R2)", 32'(take_vec), 32'(m_vec));
        chk(tag, "entry address (R3)", entry_addr, m_addr);
        chk(tag, "global enable (R7)", 32'(irq_en), 32'(m_gie));
        chk(tag, "mask (R8)", mask, m_mask);
    endtask

    task automatic idle();
        en_set = 0; en_clr = 0; mask_we = 0;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        step("R1"); step("R1");
        rst = 1'b0;
        step("R1");

        // R4: platform line ignored while enable is low
        req = 32'h0000_0400;
        step("R4"); step("R4");
        en_set = 1; step("R9"); idle();
        step("R4");                       // vector 10 taken
        step("R11"); step("R11");         // held request, no repeat

        // R5: exception taken with enable low, then masked
        req = 32'h0000_0008;
        step("R5"); step("R11"); step("R11");

        // R2: several pending, lowest wins
        req = 32'h0010_1090;
        en_set = 1; step("R2"); idle();
        step("R2"); step("R2");
        en_set = 1; step("R2"); idle();
        step("R2"); step("R2");

        // R6: NMI ignores mask and enable, edge only
        req = '0;
        mask_we = 1; mask_wdata = '0; step("R10"); idle();
        req = 32'h0000_0002;
        step("R6"); step("R6"); step("R6");
        req = '0; step("R6");
        req = 32'h0000_0002; step("R6"); step("R6");

        // R9: set and clear together, and set colliding with a take
        req = '0;
        en_set = 1; en_clr = 1; step("R9"); idle();
        mask_we = 1; mask_wdata = '1; step("R10"); idle();
        req = 32'h0000_0001;
        en_set = 1; step("R9"); idle();
        step("R9");

        // R10: mask write colliding with a take
        req = 32'h0000_0004;
        mask_we = 1; mask_wdata = 32'hFFFF_00F0; step("R10"); idle();
        mask_we = 1; mask_wdata = 32'h0000_0004; step("R10"); idle();
        step("R10"); step("R10");

        // random traffic across all rules
        for (int n = 0; n < 4000; n++) begin
            req        = $urandom & $urandom & $urandom;
            en_set     = (($urandom % 4) == 0);
            en_clr     = (($urandom % 8) == 0);
            mask_we    = (($urandom % 8) == 0);
            mask_wdata = $urandom | $urandom;
            step("R2");
        end
        idle(); req = '0;
        step("R11");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule